// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. An upstream divider supplies a one-cycle sample enable. The receiver counts those enables to time each bit. The number of samples per bit comes from a 3-bit selector. Beside the usual ratio of 16, the selector offers several odd ratios, so a convenient baud rate can be reached from a clock that does not divide by 16.

The receiver waits for the line to go low. It confirms the start bit at the middle of the bit, then takes one sample from the middle of every following bit. The line is taken least significant bit first. Character length, parity and stop length are all selectable. Each completed frame gives a one-cycle strobe with the character and its error flags. A frame that stays low from start to stop is reported as a line break instead of a character. The frame format and the ratio are captured when the start bit is seen, so a control change affects only the next frame.

Top module: `ovrx_rx`

## Requirements
- R1: `cfg_ratio_sel` sets N, the samples per bit: 0→16, 1→5, 2→7, 3→11, 4→13, 5→17, 6→19, 7→27. A frame whose bits each last N enabled samples is received correctly for every one of the eight codes.
- R2: Each bit is sampled once, at sample index floor(N/2) of that bit. Index 0 is the first enabled sample that sees the line low in idle. A level that holds only over indices floor(N/2)-1 to floor(N/2)+1 of a bit still decodes as that level.
- R3: A start edge is confirmed only if the line is still low at the start bit's midpoint. Otherwise the receiver returns to idle and reports nothing.
- R4: Data is shifted in LSB first. With `cfg_seven`=1 there are 7 data bits and `rx_data[7]` is 0. With `cfg_seven`=0 there are 8 data bits.
- R5: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over the data and parity bits; `cfg_par_odd`=1 expects an odd count. A mismatch raises `rx_par_err` together with `rx_valid`. The flag is never raised when parity is disabled.
- R6: `cfg_two_stop`=1 means two stop bits and 0 means one. If any stop bit samples low, `rx_frame_err` is raised with `rx_valid`, and the character is still delivered.
- R7: When every sampled bit of a frame, stop bits included, is low, `rx_break` pulses for one cycle and `rx_valid` does not. No new start is accepted until the line has sampled high. A long low period therefore gives exactly one break report.
- R8: The ratio and frame format are captured at the start edge. Changing the controls during a frame does not alter that frame.
- R9: `rx_valid`, `rx_break` and the error flags are registered one-cycle pulses that follow an enabled sample. The error flags never appear without `rx_valid`. After the synchronous active-high reset all outputs are 0. The line is only looked at on cycles with `smp_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle sample enable from the rate divider |
| rxd | input | 1 | Serial input line (idle high) |
| cfg_ratio_sel | input | 3 | Samples-per-bit selector |
| cfg_seven | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character strobe |
| rx_frame_err | output | 1 | Stop bit sampled low (with rx_valid) |
| rx_par_err | output | 1 | Parity mismatch (with rx_valid) |
| rx_break | output | 1 | Whole frame sampled low |

## Verification
A vector table covers all eight ratio codes across both character lengths, parity on and off with both senses, and both stop lengths. It is run once with an enable on every cycle and once with an enable on every third cycle. Most vectors drive each bit as its true value only within one sample of the midpoint and as the inverse everywhere else. A receiver that samples anywhere but floor(N/2) decodes those frames wrongly, and the clean vectors show the plain path works. Directed frames then cover the remaining cases:
- a short low glitch, to show a false start is rejected;
- corrupted parity of each sense, to show the parity flag is raised without the framing flag;
- a low first or second stop bit, to show the framing flag;
- a long low hold, to show one break report and no character;
- controls changed in mid-frame, to show the format captured at the start edge is kept.

// File: rtl/ovrx_pkg.sv
package ovrx_pkg;

  localparam int RATIO_W = 5;

  typedef enum logic [2:0] {
    ST_WAITHI,
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               seven;
    logic               par_en;
    logic               par_odd;
    logic               two_stop;
  } frame_cfg_t;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] sel);
    logic [RATIO_W-1:0] r;
    case (sel)
      3'd0:    r = RATIO_W'(16);
      3'd1:    r = RATIO_W'(5);
      3'd2:    r = RATIO_W'(7);
      3'd3:    r = RATIO_W'(11);
      3'd4:    r = RATIO_W'(13);
      3'd5:    r = RATIO_W'(17);
      3'd6:    r = RATIO_W'(19);
      default: r = RATIO_W'(27);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ovrx_sync.sv
module ovrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/ovrx_bit_timer.sv
module ovrx_bit_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_en,
  input  logic          load,
  input  logic          active,
  input  logic [CW-1:0] ratio,
  output logic          mid
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [CW-1:0] half;

  assign last = ratio - CW'(1);
  assign half = ratio >> 1;

  // Index 0 is the sample that saw the start edge, so a load sets 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (smp_en) begin
      if (load)        cnt <= CW'(1);
      else if (active) cnt <= (cnt == last) ? '0 : cnt + CW'(1);
    end
  end

  assign mid = smp_en && active && (cnt == half);
endmodule

// File: rtl/ovrx_frame_fsm.sv
module ovrx_frame_fsm
  import ovrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_en,
  input  logic              line,
  input  frame_cfg_t        cfg_in,
  input  logic              mid,
  output logic              timer_load,
  output logic              timer_active,
  output frame_cfg_t        cfg_q,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_break,
  output logic              rx_frame_err,
  output logic              rx_par_err
);
  localparam int BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] LAST_FULL  = BCW'(DATA_W - 1);
  localparam logic [BCW-1:0] LAST_SHORT = BCW'(DATA_W - 2);

  rx_state_t         state;
  logic [BCW-1:0]    bit_idx;
  logic [BCW-1:0]    last_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              par_bad;
  logic              all_low;
  logic              stop_bad;
  logic              second;
  logic              fe_now;

  assign last_idx     = cfg_q.seven ? LAST_SHORT : LAST_FULL;
  assign timer_load   = smp_en && (state == ST_IDLE) && !line;
  assign timer_active = (state == ST_START) || (state == ST_DATA) ||
                        (state == ST_PAR)   || (state == ST_STOP);
  assign fe_now       = stop_bad | ~line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAITHI;
      cfg_q        <= '0;
      bit_idx      <= '0;
      shreg        <= '0;
      par_acc      <= 1'b0;
      par_bad      <= 1'b0;
      all_low      <= 1'b0;
      stop_bad     <= 1'b0;
      second       <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_break     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_break     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
      if (smp_en) begin
        unique case (state)
          ST_WAITHI: if (line) state <= ST_IDLE;
          ST_IDLE: begin
            if (!line) begin
              state <= ST_START;
              cfg_q <= cfg_in;
            end
          end
          ST_START: begin
            if (mid) begin
              if (line) begin
                state <= ST_IDLE;
              end else begin
                state    <= ST_DATA;
                bit_idx  <= '0;
                all_low  <= 1'b1;
                par_acc  <= 1'b0;
                par_bad  <= 1'b0;
                stop_bad <= 1'b0;
                second   <= 1'b0;
              end
            end
          end
          ST_DATA: begin
            if (mid) begin
              shreg   <= {line, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              all_low <= all_low & ~line;
              if (bit_idx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
              else                     bit_idx <= bit_idx + BCW'(1);
            end
          end
          ST_PAR: begin
            if (mid) begin
              par_bad <= (par_acc ^ line) != cfg_q.par_odd;
              all_low <= all_low & ~line;
              state   <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (mid) begin
              if (cfg_q.two_stop && !second) begin
                second   <= 1'b1;
                stop_bad <= ~line;
                all_low  <= all_low & ~line;
              end else begin
                if (all_low && !line) begin
                  rx_break <= 1'b1;
                end else begin
                  rx_valid     <= 1'b1;
                  rx_data      <= cfg_q.seven ? {1'b0, shreg[DATA_W-1:1]} : shreg;
                  rx_frame_err <= fe_now;
                  rx_par_err   <= cfg_q.par_en & par_bad;
                end
                state <= line ? ST_IDLE : ST_WAITHI;
              end
            end
          end
          default: state <= ST_WAITHI;
        endcase
      end
    end
  end
endmodule

// File: rtl/ovrx_rx.sv
module ovrx_rx
  import ovrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_en,
  input  logic              rxd,
  input  logic [2:0]        cfg_ratio_sel,
  input  logic              cfg_seven,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_par_err,
  output logic              rx_break
);
  logic       line;
  logic       mid;
  logic       timer_load;
  logic       timer_active;
  frame_cfg_t cfg_in;
  frame_cfg_t cfg_q;
  logic       lat_seven;

  assign cfg_in = '{ratio:    ratio_of(cfg_ratio_sel),
                    seven:    cfg_seven,
                    par_en:   cfg_par_en,
                    par_odd:  cfg_par_odd,
                    two_stop: cfg_two_stop};
  assign lat_seven = cfg_q.seven;

  ovrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line)
  );

  ovrx_bit_timer #(.CW(RATIO_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .smp_en (smp_en),
    .load   (timer_load),
    .active (timer_active),
    .ratio  (cfg_q.ratio),
    .mid    (mid)
  );

  ovrx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .smp_en       (smp_en),
    .line         (line),
    .cfg_in       (cfg_in),
    .mid          (mid),
    .timer_load   (timer_load),
    .timer_active (timer_active),
    .cfg_q        (cfg_q),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .rx_frame_err (rx_frame_err),
    .rx_par_err   (rx_par_err)
  );
endmodule

// File: rtl/ovrx_rx_chk.sv
module ovrx_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_en,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_frame_err,
  input logic              rx_par_err,
  input logic              rx_break,
  input logic              seven_q
);
  // R9
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R9
  strobe_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid || rx_break) |-> $past(smp_en));

  // R6
  frame_err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> rx_valid);

  // R5
  par_err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rx_par_err |-> rx_valid);

  // R7
  break_not_char_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_break && rx_valid));

  // R7
  break_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_break |=> !rx_break);

  // R4
  seven_msb_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && seven_q) |-> !rx_data[DATA_W-1]);
endmodule

bind ovrx_rx ovrx_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .smp_en       (smp_en),
  .rx_data      (rx_data),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err),
  .rx_par_err   (rx_par_err),
  .rx_break     (rx_break),
  .seven_q      (lat_seven)
);

// File: tb/ovrx_rx_test.sv
module ovrx_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_en = 1'b0;
  logic       rxd = 1'b1;
  logic [2:0] cfg_ratio_sel = 3'd0;
  logic       cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_frame_err, rx_par_err, rx_break;

  ovrx_rx uut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .rxd(rxd),
    .cfg_ratio_sel(cfg_ratio_sel), .cfg_seven(cfg_seven), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_par_err(rx_par_err), .rx_break(rx_break)
  );

  always #5 clk = ~clk;

  // sample-enable source: one pulse every smp_div cycles
  int smp_div = 1;
  int divc = 0;
  always @(posedge clk) begin
    if (divc >= smp_div - 1) begin divc <= 0; smp_en <= 1'b1; end
    else begin divc <= divc + 1; smp_en <= 1'b0; end
  end

  // output monitor
  int n_valid = 0, n_break = 0;
  logic [7:0] got_data = '0;
  logic got_fe = 1'b0, got_pe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        n_valid++;
        got_data = rx_data;
        got_fe = rx_frame_err;
        got_pe = rx_par_err;
      end
      if (rx_break) n_break++;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd0: return 16; 3'd1: return 5;  3'd2: return 7;  3'd3: return 11;
      3'd4: return 13; 3'd5: return 17; 3'd6: return 19; default: return 27;
    endcase
  endfunction

  // hold the line at v for n enabled samples; starts and ends at a negedge
  task automatic hold(input bit v, input int n);
    int c;
    c = 0;
    rxd = v;
    while (c < n) begin
      if (smp_en) c++;
      @(negedge clk);
    end
  endtask

  // one bit; with gl, the true value is only present within one sample of the midpoint
  task automatic drive_bit(input bit b, input int n, input bit gl);
    int h;
    h = n / 2;
    if (gl) begin
      hold(!b, h - 1);
      hold(b, 3);
      hold(!b, n - h - 2);
    end else begin
      hold(b, n);
    end
  endtask

  task automatic send(input logic [2:0] s, input bit sv, input bit pe, input bit po, input bit ts,
                      input bit gl, input logic [7:0] d, input bit flip_par,
                      input bit [1:0] stop_low, input int chg_sel);
    int n;
    int nb;
    bit pb;
    n = ratio(s);
    nb = sv ? 7 : 8;
    cfg_ratio_sel = s; cfg_seven = sv; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    if (chg_sel >= 0) begin
      hold(1'b0, n / 2);
      cfg_ratio_sel = 3'(chg_sel); cfg_seven = ~sv; cfg_par_en = ~pe; cfg_two_stop = ~ts;
      hold(1'b0, n - n / 2);
    end else begin
      hold(1'b0, n);
    end
    for (int i = 0; i < nb; i++) drive_bit(d[i], n, gl);
    if (pe) begin
      pb = (sv ? ^d[6:0] : ^d) ^ po ^ flip_par;
      drive_bit(pb, n, gl);
    end
    hold(!stop_low[0], n);
    if (ts) hold(!stop_low[1], n);
    hold(1'b1, 2 * n);
  endtask

  task automatic clear_mon();
    n_valid = 0; n_break = 0;
  endtask

  task automatic expect_char(input string req, input logic [7:0] d, input bit fe, input bit pe);
    chk(n_valid == 1, req, "valid count", n_valid, 1);
    chk(n_break == 0, req, "break count", n_break, 0);
    chk(got_data == d, req, "data", got_data, d);
    chk(got_fe == fe, req, "frame err", got_fe, fe);
    chk(got_pe == pe, req, "parity err", got_pe, pe);
  endtask

  // {sel, seven, par_en, par_odd, two_stop, glitch, data, expected}
  localparam logic [23:0] VEC [16] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h7F},
    {3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h96, 8'h96},
    {3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h01},
    {3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hD2, 8'h52},
    {3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 8'h80},
    {3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'h5A},
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00},
    {3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFE, 8'h7E},
    {3'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'hFF},
    {3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC3, 8'hC3},
    {3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h2A},
    {3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 8'h55},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE7, 8'hE7},
    {3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33, 8'h33}
  };

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(rx_valid == 0 && rx_break == 0 && rx_frame_err == 0 && rx_par_err == 0 && rx_data == 0,
        "R9", "reset outputs", {rx_valid, rx_break, rx_frame_err, rx_par_err}, 0);
    rst = 1'b0;
    hold(1'b1, 40);

    // R1 R2 R4 R5 R6: vector table, every enabled cycle and then every third cycle
    for (int pass = 0; pass < 2; pass++) begin
      smp_div = (pass == 0) ? 1 : 3;
      hold(1'b1, 30);
      for (int k = 0; k < 16; k++) begin
        clear_mon();
        send(VEC[k][23:21], VEC[k][20], VEC[k][19], VEC[k][18], VEC[k][17], VEC[k][16],
             VEC[k][15:8], 1'b0, 2'b00, -1);
        expect_char(VEC[k][16] ? "R1/R2 table" : "R1/R4 table", VEC[k][7:0], 1'b0, 1'b0);
      end
    end
    smp_div = 1;
    hold(1'b1, 30);

    // R3: false starts at ratio 16 and 5
    clear_mon();
    cfg_ratio_sel = 3'd0; hold(1'b0, 8); hold(1'b1, 60);
    cfg_ratio_sel = 3'd1; hold(1'b0, 2); hold(1'b1, 30);
    chk(n_valid == 0 && n_break == 0, "R3", "false start output", n_valid + n_break, 0);
    clear_mon();
    send(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6B, 1'b0, 2'b00, -1);
    expect_char("R3 after false start", 8'h6B, 1'b0, 1'b0);

    // R5: wrong parity, even and odd sense
    clear_mon();
    send(3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3B, 1'b1, 2'b00, -1);
    expect_char("R5 even bad", 8'h3B, 1'b0, 1'b1);
    clear_mon();
    send(3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h41, 1'b1, 2'b00, -1);
    expect_char("R5 odd bad", 8'h41, 1'b0, 1'b1);

    // R6: framing errors
    clear_mon();
    send(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 2'b01, -1);
    expect_char("R6 single stop low", 8'h81, 1'b1, 1'b0);
    clear_mon();
    send(3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h24, 1'b0, 2'b10, -1);
    expect_char("R6 second stop low", 8'h24, 1'b1, 1'b0);
    clear_mon();
    send(3'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF0, 1'b0, 2'b01, -1);
    expect_char("R6 first stop low", 8'hF0, 1'b1, 1'b0);

    // R7: long low gives one break, then normal reception resumes
    clear_mon();
    cfg_ratio_sel = 3'd1; cfg_seven = 1'b0; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    hold(1'b0, 200);
    hold(1'b1, 20);
    chk(n_break == 1, "R7", "break count", n_break, 1);
    chk(n_valid == 0, "R7", "valid during break", n_valid, 0);
    clear_mon();
    send(3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC9, 1'b0, 2'b00, -1);
    expect_char("R7 after break", 8'hC9, 1'b0, 1'b0);

    // R8: controls changed inside the start bit do not affect the frame
    clear_mon();
    send(3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hB7, 1'b0, 2'b00, 1);
    expect_char("R8 mid-frame change", 8'hB7, 1'b0, 1'b0);
    clear_mon();
    send(3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h5C, 1'b0, 2'b00, 2);
    expect_char("R8 mid-frame change 7-bit", 8'h5C, 1'b0, 1'b0);

    finish_run();
  end
endmodule